// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a host kick line and raises a one-cycle time-out strobe when that line has shown no transition for a programmed number of clock cycles. Any change of level on the kick line counts as a kick, whether it rises or falls. The strobe goes to a reset generator, which then pulses the system reset.

The kick line passes through a two-flop synchroniser, and a transition is found by comparing the synchronised level with the level one cycle earlier. The reset generator reports back through `rst_active`. While that status is high the counter is pinned at zero. It starts counting again on the first cycle after the status drops. A separate qualifier, `kick_valid`, models a kick pin that is left floating or tri-stated. While it is low the watchdog is switched off: the counter stays at zero and no strobe is produced.

The time-out length is the parameter `TWD_CYCLES`. Suppose the kick line is held static and the reset generator holds its status for R cycles after each strobe. The strobe then repeats every R + `TWD_CYCLES` cycles.

Top module: `kick_watchdog`

## Requirements
- R1: After `TWD_CYCLES` consecutive counting cycles without a detected transition, `timeout_o` is high for exactly one cycle and the count restarts from zero on the same edge. With a static kick line and no other clearing, strobes therefore recur every `TWD_CYCLES` cycles.
- R2: A rising transition and a falling transition on `kick_in` both clear the count. A detected transition takes priority over expiry in the same cycle.
- R3: `kick_in` is sampled through two synchroniser flops. A level change that is present before rising edge K clears the count at edge K+2. A lone kick followed by silence therefore gives a strobe after edge K+2+`TWD_CYCLES`.
- R4: While `rst_active` is high the count is held at zero and no strobe is issued. Counting resumes on the first edge at which `rst_active` is low.
- R5: While `kick_valid` is low the count is held at zero and `timeout_o` stays low, whatever `kick_in` does. When `kick_valid` rises, counting starts from zero.
- R6: With a static kick line and a reset generator that holds `rst_active` for R cycles after each strobe, consecutive strobes are R + `TWD_CYCLES` cycles apart.
- R7: Synchronous reset `rst` clears the count, the synchroniser and `timeout_o`. Counting begins on the first edge after `rst` falls.
- R8: Kicks spaced P cycles apart with P ≤ `TWD_CYCLES` never produce a strobe. With P > `TWD_CYCLES`, each interval between kicks produces floor((P−1)/`TWD_CYCLES`) strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_in | input | 1 | Asynchronous host kick line; either transition is a kick |
| kick_valid | input | 1 | High when the kick line is driven; low models a floating pin and disables the watchdog |
| rst_active | input | 1 | Reset-asserted status from the reset generator; freezes the timer at zero |
| timeout_o | output | 1 | One-cycle time-out strobe requesting a reset |

## Verification
The bench builds the block with `TWD_CYCLES` = 6 and two synchroniser stages. This keeps every time-out window down to a handful of cycles, so the expected strobe pattern can be checked on every single cycle. It sweeps kick spacings from 1 up to `TWD_CYCLES`+4. That range crosses the boundary between always-kicked and multiply-expired intervals, including the case where expiry and a kick land on the same edge. A modelled reset generator with a recovery of 4 cycles closes the strobe-to-reset loop, and the qualifier is dropped both when the timer is idle and partway through a count.

// File: rtl/kick_wdt_pkg.sv
package kick_wdt_pkg;

    // Observation of the synchronised kick line
    typedef struct packed {
        logic level;
        logic toggled;
    } kick_obs_t;

    // What the timer does on the next edge
    typedef enum logic [1:0] {
        WDT_HOLD   = 2'd0,
        WDT_CLEAR  = 2'd1,
        WDT_COUNT  = 2'd2,
        WDT_EXPIRE = 2'd3
    } wdt_step_e;

    // Disarm wins over a kick, and a kick wins over expiry
    function automatic wdt_step_e pick_step(input logic armed,
                                            input logic toggled,
                                            input logic at_limit);
        if (!armed)   return WDT_HOLD;
        if (toggled)  return WDT_CLEAR;
        if (at_limit) return WDT_EXPIRE;
        return WDT_COUNT;
    endfunction

    // Bits needed to hold 0 .. limit-1
    function automatic int unsigned count_bits(input int unsigned limit);
        return (limit < 3) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/kick_edge_sync.sv
module kick_edge_sync
    import kick_wdt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      kick_in,
    output kick_obs_t obs
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_level;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= kick_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_level <= 1'b0;
        else     prev_level <= chain[SYNC_STAGES-1];
    end

    always_comb begin
        obs.level   = chain[SYNC_STAGES-1];
        obs.toggled = chain[SYNC_STAGES-1] ^ prev_level;
    end

endmodule

// File: rtl/kick_wdt_timer.sv
module kick_wdt_timer
    import kick_wdt_pkg::*;
#(
    parameter int unsigned TWD_CYCLES = 1000,
    localparam int unsigned CW = count_bits(TWD_CYCLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          armed,
    input  logic          toggled,
    output logic          timeout_o,
    output logic [CW-1:0] count_o
);

    localparam int unsigned   LAST_I = TWD_CYCLES - 1;
    localparam logic [CW-1:0] LAST   = LAST_I[CW-1:0];

    logic [CW-1:0] count_q;
    logic          strobe_q;
    wdt_step_e     step;

    always_comb step = pick_step(armed, toggled, count_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            strobe_q <= 1'b0;
        end else begin
            unique case (step)
                WDT_HOLD, WDT_CLEAR: begin
                    count_q  <= '0;
                    strobe_q <= 1'b0;
                end
                WDT_COUNT: begin
                    count_q  <= count_q + 1'b1;
                    strobe_q <= 1'b0;
                end
                WDT_EXPIRE: begin
                    count_q  <= '0;
                    strobe_q <= 1'b1;
                end
                default: begin
                    count_q  <= '0;
                    strobe_q <= 1'b0;
                end
            endcase
        end
    end

    assign timeout_o = strobe_q;
    assign count_o   = count_q;

endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
    import kick_wdt_pkg::*;
#(
    parameter int unsigned TWD_CYCLES  = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_in,
    input  logic kick_valid,
    input  logic rst_active,
    output logic timeout_o
);

    localparam int unsigned CW = count_bits(TWD_CYCLES);

    kick_obs_t     obs;
    logic          kick_toggled;
    logic          timer_armed;
    logic [CW-1:0] tick_count;

    kick_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .kick_in (kick_in),
        .obs     (obs)
    );

    assign kick_toggled = obs.toggled;
    assign timer_armed  = kick_valid & ~rst_active;

    kick_wdt_timer #(.TWD_CYCLES(TWD_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .armed     (timer_armed),
        .toggled   (kick_toggled),
        .timeout_o (timeout_o),
        .count_o   (tick_count)
    );

endmodule

// File: rtl/kick_wdt_checker.sv
module kick_wdt_checker
    import kick_wdt_pkg::*;
#(
    parameter int unsigned TWD_CYCLES = 1000,
    localparam int unsigned CW = count_bits(TWD_CYCLES)
) (
    input logic          clk,
    input logic          rst,
    input logic          kick_valid,
    input logic          rst_active,
    input logic          toggled,
    input logic [CW-1:0] count,
    input logic          timeout_o
);

    localparam int unsigned   LAST_I = TWD_CYCLES - 1;
    localparam logic [CW-1:0] LAST   = LAST_I[CW-1:0];

    // R1: count never leaves 0 .. TWD_CYCLES-1
    assert_count_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        count <= LAST);

    // R1: an expiring quiet cycle yields the strobe and a fresh count
    assert_expire_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        (kick_valid && !rst_active && !toggled && count == LAST)
        |=> (timeout_o && count == '0));

    // R1: the strobe lasts a single cycle
    assert_strobe_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    // R1: quiet armed cycles below the limit advance the count by one
    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        (kick_valid && !rst_active && !toggled && count != LAST)
        |=> (count == $past(count) + 1'b1 && !timeout_o));

    // R2: a detected transition clears and suppresses expiry
    assert_kick_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (kick_valid && !rst_active && toggled) |=> (count == '0 && !timeout_o));

    // R4: reset status freezes the timer
    assert_frozen_in_reset_R4: assert property (@(posedge clk) disable iff (rst)
        rst_active |=> (count == '0 && !timeout_o));

    // R5: floating kick line disables the watchdog
    assert_disabled_floating_R5: assert property (@(posedge clk) disable iff (rst)
        !kick_valid |=> (count == '0 && !timeout_o));

endmodule

bind kick_watchdog kick_wdt_checker #(.TWD_CYCLES(TWD_CYCLES)) u_wdt_chk (
    .clk        (clk),
    .rst        (rst),
    .kick_valid (kick_valid),
    .rst_active (rst_active),
    .toggled    (kick_toggled),
    .count      (tick_count),
    .timeout_o  (timeout_o)
);

// File: tb/test_kick_watchdog.sv
`timescale 1ns/1ps
module test_kick_watchdog;

    localparam int TWD = 6;
    localparam int REC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kick_in = 1'b0;
    logic kick_valid = 1'b1;
    logic rst_active = 1'b0;
    logic timeout_o;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    kick_watchdog #(.TWD_CYCLES(TWD), .SYNC_STAGES(2)) i_kick_watchdog (
        .clk        (clk),
        .rst        (rst),
        .kick_in    (kick_in),
        .kick_valid (kick_valid),
        .rst_active (rst_active),
        .timeout_o  (timeout_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: timeout_o actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Expected strobe for kicks starting at edge v, spaced p, m of them (R3, R8)
    function automatic bit exp_sweep(int t, int v, int p, int m);
        int c = v - 1;
        for (int k = 0; k < m; k++) begin
            int ck = v + 2 + k * p;
            if (ck == t) return 1'b0;
            if (ck < t) c = ck;
        end
        return ((t - c) > 0) && (((t - c) % TWD) == 0);
    endfunction

    task automatic run_kicks(input int p, input int m, input string req);
        int v;
        int len;
        kick_valid = 1'b0;
        repeat (4) @(negedge clk);
        v = cyc + 1;
        kick_valid = 1'b1;
        kick_in = ~kick_in;
        len = (m - 1) * p + 2 * TWD + 3;
        for (int s = 0; s < len; s++) begin
            @(negedge clk);
            chk(req, timeout_o, exp_sweep(cyc, v, p, m));
            if (((cyc + 1 - v) % p) == 0 && ((cyc + 1 - v) / p) < m) kick_in = ~kick_in;
        end
    endtask

    initial begin
        int v;
        int rcnt;
        int first;
        // R7: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R7", timeout_o, 1'b0);
        end
        rst = 1'b0;
        v = cyc;
        // R7 and R1: counting from reset release, static kick repeats every TWD
        for (int s = 0; s < 2 * TWD + 2; s++) begin
            @(negedge clk);
            chk("R1", timeout_o, ((cyc - v) > 0) && (((cyc - v) % TWD) == 0));
        end

        // R3: lone rising kick, then R2: lone falling kick
        run_kicks(1, 1, "R3");
        run_kicks(1, 1, "R2");

        // R8 and R2: sweep of kick spacing across the time-out boundary
        for (int p = 1; p <= TWD + 4; p++) run_kicks(p, 4, "R8");

        // R5: floating kick line, static and toggling
        kick_valid = 1'b0;
        for (int s = 0; s < 5 * TWD; s++) begin
            @(negedge clk);
            chk("R5", timeout_o, 1'b0);
            if ((s % 9) > 4) kick_in = ~kick_in;
        end
        // R5: qualifier drops for one cycle mid-count
        repeat (4) @(negedge clk);
        v = cyc + 1;
        kick_valid = 1'b1;
        for (int s = 0; s < 2 * TWD + 6; s++) begin
            int c;
            @(negedge clk);
            c = (cyc >= v + 3) ? v + 3 : v - 1;
            chk("R5", timeout_o, (cyc != v + 3) && ((cyc - c) > 0) && (((cyc - c) % TWD) == 0));
            kick_valid = (cyc + 1 != v + 3);
        end

        // R6 and R4: static kick with a modelled reset generator
        kick_valid = 1'b0;
        repeat (4) @(negedge clk);
        v = cyc + 1;
        kick_valid = 1'b1;
        rcnt = 0;
        first = v - 1 + TWD;
        for (int s = 0; s < 3 * (REC + TWD) + TWD; s++) begin
            @(negedge clk);
            if (rst_active) chk("R4", timeout_o, 1'b0);
            else chk("R6", timeout_o, (cyc >= first) && (((cyc - first) % (REC + TWD)) == 0));
            if (timeout_o) rcnt = REC;
            rst_active = (rcnt > 0);
            if (rcnt > 0) rcnt--;
        end
        rst_active = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #800000;
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule